// File: doc/BRIEF.md
# Random Word Conditioner

This block turns a stream of raw entropy bits into 32-bit random words. Each accepted raw bit may be scrambled by XOR with a free-running linear feedback shift register and then passed through a pair-wise bias corrector. Either stage can be used alone, both can be chained, or the raw bits can go straight to the word accumulator. When 32 conditioned bits have been gathered, the finished word is latched into a readable register and a ready flag is raised.

Software polls the status word, reads the random word, and pulses the read strobe. The strobe drops the flag and lets accumulation resume. A deterministic test mode replaces the noise input with an internal fixed-seed generator, so a whole word sequence can be predicted from reset. A global enable gates all intake. Changing the conditioning choice or dropping the enable throws away any half-built word.

Top module: `rng_conditioner`

## Requirements
- R1: Only bits [11:8] of `ctrlWord` have an effect: [9:8] select the path, [10] enables intake, [11] selects test mode. All other bits are ignored.
- R2: Path 0 shifts raw bits straight in. The first accepted bit ends at bit 31 of the word, and the word appears after its 32nd bit.
- R3: Path 1 outputs raw XOR `s[0]`. Here `s` is a 32-bit right-shifting Galois register with mask 32'h80200003 (x^32+x^22+x^2+x+1) and seed 32'h00000001. It steps once per accepted raw bit and keeps its state across flushes.
- R4: Path 2 groups conditioned bits into pairs: 01 yields 0, 10 yields 1, and 00 and 11 yield nothing.
- R5: Path 3 applies the R3 scrambler and then the R4 pair corrector. The scrambler steps on every accepted raw bit.
- R6: With bit 10 clear, no bit is accepted and `noiseValid` has no effect.
- R7: In test mode the raw bit is bit 0 of an internal Galois register (same mask as R3, seed 32'hACE12468). One bit is accepted on every cycle that intake is allowed, regardless of `noiseBit` and `noiseValid`.
- R8: `statusWord[0]` is the ready flag and the other status bits read 0. While the flag is set, intake stops and `randWord` holds.
- R9: A `rdStrobe` while the flag is set clears the flag on the next edge, and accumulation resumes with a fresh word.
- R10: A change of the path select, or a falling intake enable, discards the partial word and its pending pair, and clears the flag.
- R11: After reset, `randWord` and `statusWord` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Control word (path select, intake enable, test mode) |
| noiseBit | input | 1 | Raw entropy bit |
| noiseValid | input | 1 | Qualifies `noiseBit` |
| rdStrobe | input | 1 | Read pulse for the random word |
| randWord | output | 32 | Last completed random word |
| statusWord | output | 32 | Bit 0: a fresh word is ready |

## Verification
A wrong scrambler or test-generator state corrupts the very next finished word, so it shows up at the ports within 32 accepted bits. A stuck pair state or bit counter shifts the word boundary, which mismatches every later word. A lost flush leaves stale bits in the first word after a control change. A wrong ready-flag state shows up at the ports at once, either as a missing word or as data that changes while the flag is set.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  typedef struct packed {
    logic accept;
    logic flush;
    logic clearValid;
    logic useScr;
    logic useWhite;
    logic testMode;
  } strobe_t;
endpackage

// File: rtl/rngc_lfsr.sv
module rngc_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h0000_0001
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  output logic outBit
);
  logic [W-1:0] state;

  always_ff @(posedge clk) begin
    if (!rstN)     state <= SEED;
    else if (step) state <= (state >> 1) ^ (state[0] ? MASK : '0);
  end

  assign outBit = state[0];

  assert_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    step |=> (state != '0));
endmodule

// File: rtl/rngc_ctrl.sv
module rngc_ctrl
  import rngc_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              noiseValid,
  input  logic              rdStrobe,
  input  logic              wordDone,
  output strobe_t           strb,
  output logic              wordValid
);
  logic [1:0] sel, selQ;
  logic       noiseEn, noiseEnQ, testMode, flush;

  assign sel      = ctrlWord[9:8];
  assign noiseEn  = ctrlWord[10];
  assign testMode = ctrlWord[11];
  assign flush    = (sel != selQ) || (noiseEnQ && !noiseEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= 2'd0;
      noiseEnQ <= 1'b0;
    end else begin
      selQ     <= sel;
      noiseEnQ <= noiseEn;
    end
  end

  always_comb begin
    strb.flush      = flush;
    strb.accept     = noiseEn && (testMode || noiseValid) && !wordValid && !flush;
    strb.clearValid = rdStrobe && wordValid;
    strb.useScr     = sel[0];
    strb.useWhite   = sel[1];
    strb.testMode   = testMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                wordValid <= 1'b0;
    else if (flush)           wordValid <= 1'b0;
    else if (wordDone)        wordValid <= 1'b1;
    else if (strb.clearValid) wordValid <= 1'b0;
  end

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && wordValid) |=> !wordValid);
  assert_flush_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !wordValid);
  assert_valid_from_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordValid) |-> $past(wordDone));
endmodule

// File: rtl/rngc_datapath.sv
module rngc_datapath
  import rngc_pkg::*;
#(
  parameter int              WORD_W    = 32,
  parameter logic [31:0]     TAP_MASK  = 32'h8020_0003,
  parameter logic [31:0]     SCR_SEED  = 32'h0000_0001,
  parameter logic [31:0]     TEST_SEED = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              noiseBit,
  output logic [WORD_W-1:0] randWord,
  output logic              wordDone
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             testBit, scrBit, rawBit, condBit, outBit, emit, take;
  logic             haveFirst, firstBit;
  logic [CNT_W-1:0] bitCount;
  logic [WORD_W-1:0] acc;

  rngc_lfsr #(.W(32), .MASK(TAP_MASK), .SEED(TEST_SEED)) uTestGen (
    .clk(clk), .rstN(rstN), .step(strb.accept && strb.testMode), .outBit(testBit));

  rngc_lfsr #(.W(32), .MASK(TAP_MASK), .SEED(SCR_SEED)) uScrambler (
    .clk(clk), .rstN(rstN), .step(strb.accept && strb.useScr), .outBit(scrBit));

  always_comb begin
    rawBit  = strb.testMode ? testBit : noiseBit;
    condBit = strb.useScr ? (rawBit ^ scrBit) : rawBit;
    if (strb.useWhite) begin
      emit   = haveFirst && (firstBit != condBit);
      outBit = firstBit;
    end else begin
      emit   = 1'b1;
      outBit = condBit;
    end
    take     = strb.accept && emit;
    wordDone = take && (bitCount == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount  <= '0;
      haveFirst <= 1'b0;
      firstBit  <= 1'b0;
      acc       <= '0;
      randWord  <= '0;
    end else if (strb.flush) begin
      bitCount  <= '0;
      haveFirst <= 1'b0;
    end else if (strb.accept) begin
      if (strb.useWhite) begin
        haveFirst <= !haveFirst;
        if (!haveFirst) firstBit <= condBit;
      end
      if (take) begin
        acc      <= {acc[WORD_W-2:0], outBit};
        bitCount <= wordDone ? '0 : bitCount + 1'b1;
      end
      if (wordDone) randWord <= {acc[WORD_W-2:0], outBit};
    end
  end

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accept && !strb.flush) |=> $stable(bitCount) && $stable(haveFirst));
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (bitCount == '0) && !haveFirst);
  assert_pair_opens_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && strb.useWhite && !haveFirst) |=> haveFirst);
  assert_word_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wordDone |=> $stable(randWord));
endmodule

// File: rtl/rng_conditioner.sv
module rng_conditioner
  import rngc_pkg::*;
#(
  parameter int          CTRL_W    = 32,
  parameter int          WORD_W    = 32,
  parameter logic [31:0] TAP_MASK  = 32'h8020_0003,
  parameter logic [31:0] SCR_SEED  = 32'h0000_0001,
  parameter logic [31:0] TEST_SEED = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              noiseBit,
  input  logic              noiseValid,
  input  logic              rdStrobe,
  output logic [WORD_W-1:0] randWord,
  output logic [31:0]       statusWord
);
  strobe_t strb;
  logic    wordDone, wordValid;

  rngc_ctrl #(.CTRL_W(CTRL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .noiseValid(noiseValid),
    .rdStrobe(rdStrobe), .wordDone(wordDone), .strb(strb), .wordValid(wordValid));

  rngc_datapath #(.WORD_W(WORD_W), .TAP_MASK(TAP_MASK), .SCR_SEED(SCR_SEED),
                  .TEST_SEED(TEST_SEED)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .noiseBit(noiseBit),
    .randWord(randWord), .wordDone(wordDone));

  assign statusWord = {31'b0, wordValid};
endmodule

// File: tb/tb_rng_conditioner.sv
`timescale 1ns/1ps
module tb_rng_conditioner;
  localparam logic [31:0] TAP = 32'h8020_0003;
  localparam logic [31:0] SCR_SEED = 32'h0000_0001;
  localparam logic [31:0] TEST_SEED = 32'hACE1_2468;

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic noiseBit = 1'b0, noiseValid = 1'b0, rdStrobe = 1'b0;
  logic [31:0] randWord, statusWord;

  int checks = 0, fails = 0, mPushed = 0;
  bit monitorOn = 1'b1;
  logic [31:0] mScr, mTest, mAcc, lastExp;
  int mCnt;
  bit mHave, mFirst, mNe;
  logic [1:0] mSel;
  string curTag = "R11";
  logic [31:0] expQ[$];
  string tagQ[$];

  rng_conditioner dut (.clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .noiseBit(noiseBit),
    .noiseValid(noiseValid), .rdStrobe(rdStrobe), .randWord(randWord), .statusWord(statusWord));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] stepL(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAP : 32'h0);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelBit(input logic raw);
    logic b;
    b = raw;
    if (mSel[0]) begin b = b ^ mScr[0]; mScr = stepL(mScr); end
    if (mSel[1]) begin
      if (!mHave) begin mHave = 1; mFirst = b; return; end
      mHave = 0;
      if (mFirst == b) return;
      b = mFirst;
    end
    mAcc = {mAcc[30:0], b};
    mCnt++;
    if (mCnt == 32) begin
      expQ.push_back(mAcc); tagQ.push_back(curTag); lastExp = mAcc; mCnt = 0; mPushed++;
    end
  endtask

  function automatic logic [31:0] ctrlOf(input logic [1:0] sel, input bit ne, input bit tm);
    return {20'h5A5A5, tm, ne, sel, 8'hA5};
  endfunction

  task automatic resetDut(input logic [1:0] sel, input bit ne, input bit tm);
    rstN = 1'b0; noiseValid = 1'b0;
    ctrlWord = ctrlOf(sel, ne, tm);
    repeat (3) @(negedge clk);
    mScr = SCR_SEED; mTest = TEST_SEED; mAcc = '0; mCnt = 0; mHave = 0; mFirst = 0;
    mSel = sel; mNe = ne;
    rstN = 1'b1;
  endtask

  task automatic setCtrl(input logic [1:0] sel, input bit ne, input bit tm);
    noiseValid = 1'b0;
    if (sel != mSel || (mNe && !ne)) begin mCnt = 0; mHave = 0; end
    mSel = sel; mNe = ne;
    ctrlWord = ctrlOf(sel, ne, tm);
    @(negedge clk);
  endtask

  task automatic feed(input logic b);
    while (statusWord[0]) begin noiseValid = 1'b0; @(negedge clk); end
    noiseValid = 1'b1; noiseBit = b;
    if (mNe) modelBit(b);
    @(negedge clk);
    noiseValid = 1'b0;
  endtask

  task automatic feedWord(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) feed(w[i]);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected words as the design finishes them
  initial begin
    forever begin
      @(negedge clk);
      if (monitorOn && rstN && statusWord[0] && !rdStrobe) begin
        if (expQ.size() == 0) check(1'b0, "R8 unexpected word", randWord, 32'h0);
        else begin
          logic [31:0] e; string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          check(randWord === e, t, randWord, e);
        end
        rdStrobe = 1'b1;
      end else rdStrobe = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    resetDut(2'd0, 1'b1, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    check(randWord === 32'h0, "R11 randWord", randWord, 32'h0);
    check(statusWord === 32'h0, "R11 status", statusWord, 32'h0);

    // R7 test mode, raw path: noise inputs toggled but ignored
    resetDut(2'd0, 1'b1, 1'b1);
    curTag = "R7";
    while (mPushed < 3) begin logic r; r = mTest[0]; mTest = stepL(mTest); modelBit(r); end
    while (expQ.size() != 0) begin
      noiseBit = 1'($urandom); noiseValid = 1'($urandom); @(negedge clk);
    end
    noiseValid = 1'b0;

    // R5 chained path driven by the test generator (R7)
    resetDut(2'd3, 1'b1, 1'b1);
    curTag = "R5 R7";
    mPushed = 0;
    while (mPushed < 2) begin logic r; r = mTest[0]; mTest = stepL(mTest); modelBit(r); end
    drain();

    // R2 raw path from noise; R1 low and high ctrl bits are junk
    resetDut(2'd0, 1'b1, 1'b0);
    @(negedge clk);
    curTag = "R2 R1";
    feedWord(32'hDEAD_BEEF);
    feedWord($urandom);
    drain();

    // R8 hold while ready, extra noise ignored
    monitorOn = 1'b0;
    curTag = "R8";
    feedWord(32'h1234_5678);
    @(negedge clk);
    check(statusWord === 32'h1, "R8 ready flag", statusWord, 32'h1);
    for (int i = 0; i < 5; i++) begin
      noiseValid = 1'b1; noiseBit = i[0]; @(negedge clk);
    end
    noiseValid = 1'b0;
    check(randWord === 32'h1234_5678, "R8 word held", randWord, 32'h1234_5678);
    check(statusWord === 32'h1, "R8 flag held", statusWord, 32'h1);
    monitorOn = 1'b1;
    drain();
    check(statusWord === 32'h0, "R9 read clears flag", statusWord, 32'h0);
    curTag = "R9";
    feedWord(32'h0F0F_F0F0);
    drain();

    // R3 scrambler
    setCtrl(2'd1, 1'b1, 1'b0);
    curTag = "R3";
    feedWord($urandom); feedWord($urandom);
    drain();

    // R4 pair corrector
    setCtrl(2'd2, 1'b1, 1'b0);
    curTag = "R4";
    mPushed = 0;
    while (mPushed < 2) feed(1'($urandom));
    drain();

    // R6 intake disabled, R10 flush on enable fall
    setCtrl(2'd0, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) feed(1'b1);
    setCtrl(2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) feed(1'($urandom));
    check(statusWord === 32'h0, "R6 no word while disabled", statusWord, 32'h0);
    check(randWord === lastExp, "R6 word unchanged", randWord, lastExp);
    setCtrl(2'd0, 1'b1, 1'b0);
    curTag = "R10 R6";
    feedWord(32'hCAFE_F00D);
    drain();

    // R10 flush on select change mid-word
    for (int i = 0; i < 13; i++) feed(1'b0);
    setCtrl(2'd1, 1'b1, 1'b0);
    curTag = "R10 R3";
    feedWord($urandom); feedWord($urandom);
    drain();

    // R10 pending word dropped by a select change
    monitorOn = 1'b0;
    setCtrl(2'd0, 1'b1, 1'b0);
    feedWord(32'h5555_AAAA);
    @(negedge clk);
    check(statusWord === 32'h1, "R10 word pending", statusWord, 32'h1);
    setCtrl(2'd3, 1'b1, 1'b0);
    check(statusWord === 32'h0, "R10 flush clears flag", statusWord, 32'h0);
    void'(expQ.pop_front()); void'(tagQ.pop_front());
    monitorOn = 1'b1;
    curTag = "R5";
    mPushed = 0;
    while (mPushed < 1) feed(1'($urandom));
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule